// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block produces the serial clock for a serial-peripheral master from the main clock. It divides in two stages. A power-of-two prescaler runs first and divides by 2, 4, 8 or 16, chosen by a 2-bit select. A programmable stage follows and divides that tick train by 2×(B+1), where B is a 6-bit baud field. The serial clock rests at a selectable idle level. Two single-cycle strobes mark the edge that leaves the idle level (leading) and the edge that returns to it (trailing), so that shift logic can sample and launch on them.

The prescale select, the baud field and the idle level are captured only while the enable is low. A running clock therefore never sees a change in the middle of a period, and no shortened pulse can appear. Baud values below 4 are raised to 4.

A separate combinational helper takes a requested divide ratio R (main clock over target rate) and returns the best legal prescale/baud pair. It clamps at both ends of the reachable range, which runs from main/20 to main/2048.

Top module: `sclk_div`

## Requirements
- R1: During and after synchronous reset, `sclk_o` is 0 and both strobes are 0. The effective setting is prescale 0, baud 4, idle level 0, and it stays so until the enable is first seen low.
- R2: With enable high, the serial clock changes level every H = (2 << P) × (B + 1) main-clock cycles, where P is the captured prescale and B the captured baud. The first change comes H cycles after the first rising edge that samples the enable high, giving a period between 20 and 2048 cycles.
- R3: A captured baud value below 4 behaves exactly as a baud value of 4.
- R4: While enable is low, `sclk_o` equals the idle-level input one cycle later, no strobe is produced, and both counters restart from zero.
- R5: `lead_stb_o` is a one-cycle pulse in the cycle `sclk_o` moves from the idle level to the active level. `trail_stb_o` is a one-cycle pulse in the cycle `sclk_o` returns to the idle level. The two are never high together.
- R6: Prescale, baud and idle level are captured only on cycles where enable is low. Changes while enable is high have no effect on the running clock.
- R7: The helper tries prescale values d = 0, 1, 2, 3 in order and computes Q = R >> (d + 2). At the first d with 5 ≤ Q ≤ 64 it outputs prescale d and baud Q − 1.
- R8: If Q < 5 at the first prescale tried (the target is too fast), the helper outputs that prescale with baud 4. Every helper baud output lies in 4..63.
- R9: If no prescale in 0..3 gives Q ≤ 64 (the target is too slow), the helper outputs prescale 3 and baud 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; settings are captured while low |
| idle_lvl_i | input | 1 | Level of the serial clock when idle |
| pre_sel_i | input | PRE_W | Prescale select P; divides by 2 << P |
| baud_sel_i | input | BAUD_W | Baud field B; divides by 2×(B+1), raised to at least 4 |
| ratio_i | input | RATIO_W | Requested divide ratio for the helper |
| sclk_o | output | 1 | Serial clock |
| lead_stb_o | output | 1 | Pulse on the idle-to-active edge |
| trail_stb_o | output | 1 | Pulse on the active-to-idle edge |
| map_pre_o | output | PRE_W | Helper prescale result |
| map_baud_o | output | BAUD_W | Helper baud result |

## Verification
The assertions check the following on every cycle:
- the strobes are exclusive and last one cycle;
- each strobe agrees with the new level of the serial clock;
- the output stays quiet and at the idle level while disabled;
- the captured setting is frozen while running;
- the captured baud and the helper's baud stay inside the legal range.

The exact half-period for each setting, the delay to the first edge after enable, the clamping of low baud values and the helper's choice among prescale candidates depend on counted cycles and chosen ratios. Only the bench's vectors and directed cases can show these.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int PRE_W_DEF    = 2;
  localparam int BAUD_W_DEF   = 6;
  localparam int BAUD_MIN_DEF = 4;
  localparam int RATIO_W_DEF  = 16;

  typedef enum logic {PH_IDLE = 1'b0, PH_ACTIVE = 1'b1} sclk_phase_e;
endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int PRE_W = sclk_div_pkg::PRE_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = 1 << PRE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   term_full;
  logic [CNT_W-1:0] term;

  always_comb begin
    term_full = ((CNT_W+1)'(1) << (int'(sel_i) + 1)) - (CNT_W+1)'(1);
    term      = term_full[CNT_W-1:0];
  end

  assign tick_o = run_i && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst || !run_i)   cnt_q <= '0;
    else if (cnt_q == term) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= term); // R2
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen #(
  parameter int BAUD_W   = sclk_div_pkg::BAUD_W_DEF,
  parameter int BAUD_MIN = sclk_div_pkg::BAUD_MIN_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              idle_q_i,
  input  logic              idle_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  import sclk_div_pkg::*;

  logic [BAUD_W-1:0] cnt_q;
  sclk_phase_e       phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= PH_IDLE;
      sclk_o  <= idle_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == baud_i) begin
          cnt_q   <= '0;
          sclk_o  <= ~sclk_o;
          phase_q <= (phase_q == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
          lead_o  <= (phase_q == PH_IDLE);
          trail_o <= (phase_q == PH_ACTIVE);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_BAUD_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= baud_i); // R2
  AST_BAUD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    baud_i >= BAUD_W'(BAUD_MIN)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lead_o && trail_o)); // R5
  AST_LEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lead_o |=> !lead_o); // R5
  AST_TRAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trail_o |=> !trail_o); // R5
  AST_LEAD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    lead_o |-> (sclk_o != idle_q_i)); // R5
  AST_TRAIL_IDLE: assert property (@(posedge clk) disable iff (rst)
    trail_o |-> (sclk_o == idle_q_i)); // R5
endmodule

// File: rtl/sclk_rate_map.sv
module sclk_rate_map #(
  parameter int PRE_W    = sclk_div_pkg::PRE_W_DEF,
  parameter int BAUD_W   = sclk_div_pkg::BAUD_W_DEF,
  parameter int BAUD_MIN = sclk_div_pkg::BAUD_MIN_DEF,
  parameter int RATIO_W  = sclk_div_pkg::RATIO_W_DEF
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [PRE_W-1:0]   pre_o,
  output logic [BAUD_W-1:0]  baud_o
);
  localparam int NDIV = 1 << PRE_W;
  localparam logic [RATIO_W-1:0] Q_LOW  = RATIO_W'(BAUD_MIN + 1);
  localparam logic [RATIO_W-1:0] Q_HIGH = RATIO_W'(1 << BAUD_W);

  logic [RATIO_W-1:0] quot [NDIV];
  logic [NDIV-1:0]    too_fast;
  logic [NDIV-1:0]    fits;

  for (genvar d = 0; d < NDIV; d++) begin : g_cand
    assign quot[d]     = ratio_i >> (d + 2);
    assign too_fast[d] = quot[d] < Q_LOW;
    assign fits[d]     = quot[d] <= Q_HIGH;
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    pre_o  = PRE_W'(NDIV - 1);
    baud_o = {BAUD_W{1'b1}};
    for (int d = 0; d < NDIV; d++) begin
      if (!found && too_fast[d]) begin
        found  = 1'b1;
        pre_o  = PRE_W'(d);
        baud_o = BAUD_W'(BAUD_MIN);
      end else if (!found && fits[d]) begin
        found  = 1'b1;
        pre_o  = PRE_W'(d);
        baud_o = BAUD_W'(quot[d] - 1'b1);
      end
    end
  end

  always_comb begin
    if (!$isunknown(ratio_i)) begin
      AST_MAP_RANGE: assert (baud_o >= BAUD_W'(BAUD_MIN)); // R8
    end
  end
endmodule

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int PRE_W    = sclk_div_pkg::PRE_W_DEF,
  parameter int BAUD_W   = sclk_div_pkg::BAUD_W_DEF,
  parameter int BAUD_MIN = sclk_div_pkg::BAUD_MIN_DEF,
  parameter int RATIO_W  = sclk_div_pkg::RATIO_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               idle_lvl_i,
  input  logic [PRE_W-1:0]   pre_sel_i,
  input  logic [BAUD_W-1:0]  baud_sel_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sclk_o,
  output logic               lead_stb_o,
  output logic               trail_stb_o,
  output logic [PRE_W-1:0]   map_pre_o,
  output logic [BAUD_W-1:0]  map_baud_o
);
  localparam logic [BAUD_W-1:0] BMIN = BAUD_W'(BAUD_MIN);

  logic [PRE_W-1:0]  pre_q;
  logic [BAUD_W-1:0] baud_q;
  logic              idle_q;
  logic              tick;

  // settings are captured only while stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      baud_q <= BMIN;
      idle_q <= 1'b0;
    end else if (!en_i) begin
      pre_q  <= pre_sel_i;
      baud_q <= (baud_sel_i < BMIN) ? BMIN : baud_sel_i;
      idle_q <= idle_lvl_i;
    end
  end

  sclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_i  (en_i),
    .sel_i  (pre_q),
    .tick_o (tick)
  );

  sclk_edge_gen #(.BAUD_W(BAUD_W), .BAUD_MIN(BAUD_MIN)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .run_i    (en_i),
    .tick_i   (tick),
    .baud_i   (baud_q),
    .idle_q_i (idle_q),
    .idle_i   (idle_lvl_i),
    .sclk_o   (sclk_o),
    .lead_o   (lead_stb_o),
    .trail_o  (trail_stb_o)
  );

  sclk_rate_map #(.PRE_W(PRE_W), .BAUD_W(BAUD_W), .BAUD_MIN(BAUD_MIN),
                  .RATIO_W(RATIO_W)) u_map (
    .ratio_i (ratio_i),
    .pre_o   (map_pre_o),
    .baud_o  (map_baud_o)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    en_i |=> ($stable(pre_q) && $stable(baud_q) && $stable(idle_q))); // R6
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!lead_stb_o && !trail_stb_o && (sclk_o == $past(idle_lvl_i)))); // R4
endmodule

// File: tb/sclk_div_tb_top.sv
module sclk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic        idle_lvl_i = 1'b0;
  logic [1:0]  pre_sel_i = '0;
  logic [5:0]  baud_sel_i = 6'd4;
  logic [15:0] ratio_i = '0;
  logic        sclk_o, lead_stb_o, trail_stb_o;
  logic [1:0]  map_pre_o;
  logic [5:0]  map_baud_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sclk_div dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .idle_lvl_i(idle_lvl_i),
    .pre_sel_i(pre_sel_i), .baud_sel_i(baud_sel_i), .ratio_i(ratio_i),
    .sclk_o(sclk_o), .lead_stb_o(lead_stb_o), .trail_stb_o(trail_stb_o),
    .map_pre_o(map_pre_o), .map_baud_o(map_baud_o)
  );

  typedef struct packed {
    logic [15:0] ratio;
    logic [1:0]  pre;
    logic [5:0]  baud;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{16'd20,   2'd0, 6'd4,  4'd7},  // fastest legal
    '{16'd10,   2'd0, 6'd4,  4'd8},  // too fast
    '{16'd0,    2'd0, 6'd4,  4'd8},  // too fast, zero ratio
    '{16'd40,   2'd0, 6'd9,  4'd7},
    '{16'd256,  2'd0, 6'd63, 4'd7},  // top of first stage
    '{16'd260,  2'd1, 6'd31, 4'd7},  // needs second prescale
    '{16'd1000, 2'd2, 6'd61, 4'd7},
    '{16'd2048, 2'd3, 6'd63, 4'd7},  // slowest legal
    '{16'd5000, 2'd3, 6'd63, 4'd9}   // too slow
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // counts negedges until the strobe is seen
  task automatic wait_strobe(input bit want_lead, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((want_lead ? lead_stb_o : trail_stb_o) == 1'b0) && n < 5000);
  endtask

  task automatic measure(input int pre, input int baud, input bit idle,
                         input int exp_h, input string req);
    int n;
    en_i = 1'b0;
    idle_lvl_i = idle;
    pre_sel_i = 2'(pre);
    baud_sel_i = 6'(baud);
    @(negedge clk);
    @(negedge clk);
    chk(int'(sclk_o), int'(idle), "R4", "idle level while stopped");
    en_i = 1'b1;
    wait_strobe(1'b1, n);
    chk(n, exp_h, req, "cycles to leading edge");
    chk(int'(sclk_o), int'(!idle), "R5", "level at leading strobe");
    wait_strobe(1'b0, n);
    chk(n, exp_h, req, "cycles to trailing edge");
    chk(int'(sclk_o), int'(idle), "R5", "level at trailing strobe");
    en_i = 1'b0;
    @(negedge clk);
    chk(int'(lead_stb_o | trail_stb_o), 0, "R4", "no strobe when stopped");
    chk(int'(sclk_o), int'(idle), "R4", "level after stop");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    // R1: reset state, with enable and odd settings held through reset
    en_i = 1'b1;
    pre_sel_i = 2'd3;
    baud_sel_i = 6'd63;
    repeat (3) @(negedge clk);
    chk(int'(sclk_o), 0, "R1", "sclk in reset");
    chk(int'(lead_stb_o | trail_stb_o), 0, "R1", "strobes in reset");
    rst = 1'b0;
    wait_strobe(1'b1, n);
    chk(n, 10, "R1", "default setting half period");
    en_i = 1'b0;
    @(negedge clk);

    // R2 / R7 / R8 / R9: table of ratios, helper result then divider timing
    for (int i = 0; i < NVEC; i++) begin
      ratio_i = VECS[i].ratio;
      @(negedge clk);
      chk(int'(map_pre_o), int'(VECS[i].pre), req_name(VECS[i].req), "helper prescale");
      chk(int'(map_baud_o), int'(VECS[i].baud), req_name(VECS[i].req), "helper baud");
      measure(int'(VECS[i].pre), int'(VECS[i].baud), i[0],
              (2 << VECS[i].pre) * (int'(VECS[i].baud) + 1), "R2");
    end

    // R3: illegal low baud values act as 4
    measure(0, 2, 1'b0, 10, "R3");
    measure(1, 0, 1'b1, 20, "R3");

    // R6: settings changed while running are ignored
    en_i = 1'b0;
    idle_lvl_i = 1'b0;
    pre_sel_i = 2'd0;
    baud_sel_i = 6'd4;
    @(negedge clk);
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
    pre_sel_i = 2'd3;
    baud_sel_i = 6'd63;
    idle_lvl_i = 1'b1;
    wait_strobe(1'b1, n);
    chk(n + 1, 10, "R6", "leading edge after live change");
    chk(int'(sclk_o), 1, "R6", "active level kept");
    wait_strobe(1'b0, n);
    chk(n, 10, "R6", "trailing edge after live change");
    chk(int'(sclk_o), 0, "R6", "idle level kept");

    // R4: stop mid-period, output follows the idle input at once
    repeat (4) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk(int'(sclk_o), 1, "R4", "follows idle input after stop");
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      n += int'(lead_stb_o | trail_stb_o);
    end
    chk(n, 0, "R4", "strobes over 40 stopped cycles");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule